// File: doc/BRIEF.md
# Mode-Selectable Three-Input Logic Cell

A clocked single-bit logic cell with three data inputs (`in_a`, `in_b`, `in_c`), a trigger input and a mode word. On each clock edge where `en` is high the cell takes one evaluation step. A step computes one function picked by the active mode and registers the result on `out`. The function is a gate or a hold function on a chosen pair of inputs, or a function of all three inputs. It can be followed by a post-stage that merges the pair result with `in_c`.

Two module parameters bias the inputs. The effective mode is `mode_in + MODE_BIAS`. The update policy is `(upd_in + UPD_BIAS) mod 5`. The policy decides whether the effective mode replaces the held mode in a step, or whether the output is captured on trigger edges. The cell is meant for control glue where one physical cell is reconfigured among many small Boolean and latch behaviours.

Top module: `tri_logic_cell`

## Requirements
- R1: A synchronous active-high `rst` clears `out`, the held mode (to 0, the AND of `in_a`,`in_b`), the hold bit, its arm flag, the post-stage result, the trigger arm flag and the capture register.
- R2: On a clock edge with `en` low, no state changes and `out` keeps its value.
- R3: For active mode values below 32, bits [4:3] pick the source: 0=(a,b), 1=(a,c), 2=(b,c), 3=all three. For the three pair sources, bits [2:0] pick the function: 0 AND, 1 NAND, 2 OR, 3 NOR, 4 XOR, 5 XNOR, 6 sample-and-hold, 7 track-and-hold. Outside the trigger policy, the result is on `out` one clock after the enabled edge.
- R4: Sample-and-hold (function 6) loads the first input of the pair into the hold bit when the second input is high and the arm flag is clear, and sets the flag. The flag clears at a step where the second input is low. The result is the updated hold bit.
- R5: Track-and-hold (function 7) copies the first input of the pair into the hold bit while the second input is high. Otherwise it keeps the bit. The result is the updated hold bit.
- R6: Source 3 uses bits [2:0] as follows: 0 AND3, 1 NAND3, 2 OR3, 3 NOR3, 4 true for 1 or 3 high inputs, 5 true for 0 or 2 high inputs, 6 true for exactly one high input, 7 true for exactly two high inputs.
- R7: For active modes of 32 and above, bits [2:0] pick a pair-(a,b) function from R3. Bits [4:3] pick a post-stage: 0 AND with `in_c`, 1 force 0 while `in_c` is high, 2 invert while `in_c` is high, 3 take the new result while `in_c` is high and otherwise keep the previous post-stage result.
- R8: The effective mode is `(mode_in + MODE_BIAS) mod 2^MW`. Modes 48 to 63 decode the invert and keep post-stages.
- R9: Policy = `(upd_in + UPD_BIAS) mod 5`. Policies 0 and 4 accept the effective mode every step. Policy 1 accepts only when `in_a` differs from its value at the previous enabled step. Policy 2 does the same for `in_b`, and policy 3 accepts when either input differs. The accepted mode is used in the same step. The previous values of `in_a` and `in_b` are refreshed at every enabled step.
- R10: In policy 4 the output shows the capture register as it stood before the step. When `trig` is high and the trigger arm flag is clear, the step stores the combined result and sets the flag. The flag clears when `trig` is low in a policy-4 step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Evaluation step enable |
| in_a | input | 1 | Data input 1 |
| in_b | input | 1 | Data input 2 |
| in_c | input | 1 | Data input 3 |
| trig | input | 1 | Capture trigger for policy 4 |
| mode_in | input | MW | Mode word before bias |
| upd_in | input | UW | Update selector before bias |
| out | output | 1 | Registered result |

## Verification
The bench goes after several corner cases:
- **Mode wrap:** a sum above 63 must wrap to a low mode. A cell that widened the sum would land on a post-stage mode instead.
- **Change-gated policies:** an unchanged `in_a` must keep the old mode. A cell that refreshed the mode anyway would switch function early, and one that skipped refreshing the previous-input register would mis-detect later changes.
- **Sample-and-hold arm flag:** a cell that ignored the flag would track like function 7.
- **Trigger policy:** the output is one capture late. A cell that passed the new capture straight through would lead by one step.
- **Random coverage:** long random runs across all modes and policies compare every step with an independent model. They catch wrong group ordering and hold bits shared incorrectly between modes.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

    typedef enum logic [2:0] {
        POL_DIRECT  = 3'd0,
        POL_CHG_A   = 3'd1,
        POL_CHG_B   = 3'd2,
        POL_CHG_ANY = 3'd3,
        POL_TRIG    = 3'd4
    } policy_e;

    typedef enum logic [1:0] {
        SRC_AB  = 2'd0,
        SRC_AC  = 2'd1,
        SRC_BC  = 2'd2,
        SRC_ABC = 2'd3
    } src_e;

    typedef enum logic [2:0] {
        F_AND    = 3'd0,
        F_NAND   = 3'd1,
        F_OR     = 3'd2,
        F_NOR    = 3'd3,
        F_XOR    = 3'd4,
        F_XNOR   = 3'd5,
        F_SAMPLE = 3'd6,
        F_TRACK  = 3'd7
    } func_e;

    typedef enum logic [1:0] {
        P_GATE   = 2'd0,
        P_FORCE0 = 2'd1,
        P_INVERT = 2'd2,
        P_KEEP   = 2'd3
    } post_e;

    typedef struct packed {
        logic  post_en;
        post_e post;
        src_e  src;
        func_e func;
    } dec_t;

    // low5 equals (mode - 32) modulo 32 for any mode >= 32
    function automatic dec_t decode_mode(input logic post_en, input logic [4:0] low5);
        dec_t d;
        d.post_en = post_en;
        d.func    = func_e'(low5[2:0]);
        d.post    = post_e'(low5[4:3]);
        d.src     = post_en ? SRC_AB : src_e'(low5[4:3]);
        return d;
    endfunction

    function automatic logic pair_gate(input func_e f, input logic x, input logic y);
        logic r;
        case (f)
            F_AND:   r = x & y;
            F_NAND:  r = ~(x & y);
            F_OR:    r = x | y;
            F_NOR:   r = ~(x | y);
            F_XOR:   r = x ^ y;
            F_XNOR:  r = ~(x ^ y);
            default: r = 1'b0;
        endcase
        return r;
    endfunction

    function automatic logic tri_gate(input func_e f, input logic a, input logic b, input logic c);
        logic [1:0] cnt;
        logic r;
        cnt = {1'b0, a} + {1'b0, b} + {1'b0, c};
        case (f)
            F_AND:    r = a & b & c;
            F_NAND:   r = ~(a & b & c);
            F_OR:     r = a | b | c;
            F_NOR:    r = ~(a | b | c);
            F_XOR:    r = cnt[0];
            F_XNOR:   r = ~cnt[0];
            F_SAMPLE: r = (cnt == 2'd1);
            default:  r = (cnt == 2'd2);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tlc_mode_ctl.sv
module tlc_mode_ctl
    import tlc_pkg::*;
#(
    parameter int unsigned MW = 6,
    parameter int unsigned UW = 3,
    parameter int unsigned UPD_BIAS = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          in_a,
    input  logic          in_b,
    input  logic [MW-1:0] mode_eff,
    input  logic [UW-1:0] upd_in,
    output policy_e       policy,
    output logic [MW-1:0] active_mode,
    output logic [MW-1:0] held_mode,
    output logic          prev_a
);
    localparam int unsigned SW = UW + 1;

    logic [SW-1:0] upd_sum;
    logic [SW-1:0] upd_rem;
    logic          prev_b;
    logic          accept;

    assign upd_sum = {1'b0, upd_in} + SW'(UPD_BIAS);
    assign upd_rem = upd_sum % SW'(5);
    assign policy  = policy_e'(upd_rem[2:0]);

    always_comb begin
        case (policy)
            POL_CHG_A:   accept = (in_a != prev_a);
            POL_CHG_B:   accept = (in_b != prev_b);
            POL_CHG_ANY: accept = (in_a != prev_a) || (in_b != prev_b);
            default:     accept = 1'b1;
        endcase
    end

    assign active_mode = accept ? mode_eff : held_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_mode <= '0;
            prev_a    <= 1'b0;
            prev_b    <= 1'b0;
        end else if (en) begin
            held_mode <= active_mode;
            prev_a    <= in_a;
            prev_b    <= in_b;
        end
    end
endmodule

// File: rtl/tlc_eval.sv
module tlc_eval
    import tlc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic in_a,
    input  logic in_b,
    input  logic in_c,
    input  dec_t dec,
    output logic result
);
    logic hold_q, arm_q, post_q;
    logic hold_n, arm_n;
    logic x, y, base;

    always_comb begin
        case (dec.src)
            SRC_AC:  begin x = in_a; y = in_c; end
            SRC_BC:  begin x = in_b; y = in_c; end
            default: begin x = in_a; y = in_b; end
        endcase
    end

    always_comb begin
        hold_n = hold_q;
        arm_n  = arm_q;
        if (dec.src == SRC_ABC) begin
            base = tri_gate(dec.func, in_a, in_b, in_c);
        end else begin
            case (dec.func)
                F_SAMPLE: begin
                    if (y && !arm_q) begin
                        hold_n = x;
                        arm_n  = 1'b1;
                    end else if (arm_q && !y) begin
                        arm_n = 1'b0;
                    end
                    base = hold_n;
                end
                F_TRACK: begin
                    if (y) hold_n = x;
                    base = hold_n;
                end
                default: base = pair_gate(dec.func, x, y);
            endcase
        end
    end

    always_comb begin
        if (dec.post_en) begin
            case (dec.post)
                P_GATE:   result = in_c & base;
                P_FORCE0: result = in_c ? 1'b0 : base;
                P_INVERT: result = in_c ^ base;
                default:  result = in_c ? base : post_q;
            endcase
        end else begin
            result = base;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= 1'b0;
            arm_q  <= 1'b0;
            post_q <= 1'b0;
        end else if (en) begin
            hold_q <= hold_n;
            arm_q  <= arm_n;
            post_q <= result;
        end
    end
endmodule

// File: rtl/tlc_capture.sv
module tlc_capture
    import tlc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    en,
    input  logic    trig,
    input  policy_e policy,
    input  logic    result,
    output logic    cap_q,
    output logic    out_q
);
    logic tarm_q, tarm_n, cap_n, shown;

    always_comb begin
        tarm_n = tarm_q;
        cap_n  = cap_q;
        if (policy == POL_TRIG) begin
            shown = cap_q;
            if (trig && !tarm_q) begin
                tarm_n = 1'b1;
                cap_n  = result;
            end else if (tarm_q && !trig) begin
                tarm_n = 1'b0;
            end
        end else begin
            shown = result;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tarm_q <= 1'b0;
            cap_q  <= 1'b0;
            out_q  <= 1'b0;
        end else if (en) begin
            tarm_q <= tarm_n;
            cap_q  <= cap_n;
            out_q  <= shown;
        end
    end
endmodule

// File: rtl/tri_logic_cell.sv
module tri_logic_cell
    import tlc_pkg::*;
#(
    parameter int unsigned MW = 6,
    parameter int unsigned UW = 3,
    parameter int unsigned MODE_BIAS = 0,
    parameter int unsigned UPD_BIAS = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          in_a,
    input  logic          in_b,
    input  logic          in_c,
    input  logic          trig,
    input  logic [MW-1:0] mode_in,
    input  logic [UW-1:0] upd_in,
    output logic          out
);
    logic [MW-1:0] mode_eff;
    logic [MW-1:0] active_mode;
    logic [MW-1:0] held_mode;
    logic          prev_a;
    logic          post_en;
    policy_e       policy;
    dec_t          dec;
    logic          result;
    logic          cap_q;

    assign mode_eff = mode_in + MW'(MODE_BIAS);

    tlc_mode_ctl #(.MW(MW), .UW(UW), .UPD_BIAS(UPD_BIAS)) u_ctl (
        .clk(clk), .rst(rst), .en(en), .in_a(in_a), .in_b(in_b),
        .mode_eff(mode_eff), .upd_in(upd_in), .policy(policy),
        .active_mode(active_mode), .held_mode(held_mode), .prev_a(prev_a)
    );

    assign post_en = (active_mode[MW-1:5] != '0);
    assign dec     = decode_mode(post_en, active_mode[4:0]);

    tlc_eval u_eval (
        .clk(clk), .rst(rst), .en(en), .in_a(in_a), .in_b(in_b),
        .in_c(in_c), .dec(dec), .result(result)
    );

    tlc_capture u_cap (
        .clk(clk), .rst(rst), .en(en), .trig(trig), .policy(policy),
        .result(result), .cap_q(cap_q), .out_q(out)
    );
endmodule

// File: rtl/tlc_checker.sv
module tlc_checker #(
    parameter int unsigned MW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          en,
    input logic          in_a,
    input logic          in_b,
    input logic          out,
    input logic [2:0]    policy,
    input logic [MW-1:0] active_mode,
    input logic [MW-1:0] held_mode,
    input logic          prev_a,
    input logic          cap_q
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (out == 1'b0 && held_mode == '0 && cap_q == 1'b0));

    a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(out) && $stable(held_mode) && $stable(cap_q)));

    a_r3_and_pair: assert property (@(posedge clk) disable iff (rst)
        (en && active_mode == '0 && policy != 3'd4) |=> (out == $past(in_a & in_b)));

    a_r9_no_change_keeps_mode: assert property (@(posedge clk) disable iff (rst)
        (en && policy == 3'd1 && in_a == prev_a) |=> (held_mode == $past(held_mode)));

    a_r10_trig_lags: assert property (@(posedge clk) disable iff (rst)
        (en && policy == 3'd4) |=> (out == $past(cap_q)));
endmodule

bind tri_logic_cell tlc_checker #(.MW(MW)) chk_i (
    .clk(clk), .rst(rst), .en(en), .in_a(in_a), .in_b(in_b), .out(out),
    .policy(policy), .active_mode(active_mode), .held_mode(held_mode),
    .prev_a(prev_a), .cap_q(cap_q)
);

// File: tb/tri_logic_cell_tb_top.sv
module tri_logic_cell_tb_top;
    localparam int MB = 5;
    localparam int UB = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       in_a = 1'b0, in_b = 1'b0, in_c = 1'b0, trig = 1'b0;
    logic [5:0] mode_in = '0;
    logic [2:0] upd_in = '0;
    logic       out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // independent model state
    int m_held, m_pa, m_pb, m_hb, m_arm, m_post, m_tarm, m_cap, m_out;
    int m_pol, m_act;

    always #2 clk = ~clk;

    tri_logic_cell #(.MW(6), .UW(3), .MODE_BIAS(MB), .UPD_BIAS(UB)) dut_i (
        .clk(clk), .rst(rst), .en(en), .in_a(in_a), .in_b(in_b), .in_c(in_c),
        .trig(trig), .mode_in(mode_in), .upd_in(upd_in), .out(out)
    );

    function automatic string auto_tag(int pol, int act);
        if (pol == 4) return "R10";
        if (act >= 32) return "R7";
        if (act / 8 == 3) return "R6";
        if (act % 8 == 6) return "R4";
        if (act % 8 == 7) return "R5";
        return "R3";
    endfunction

    task automatic model_reset();
        m_held = 0; m_pa = 0; m_pb = 0; m_hb = 0; m_arm = 0;
        m_post = 0; m_tarm = 0; m_cap = 0; m_out = 0;
    endtask

    task automatic model_step(int a, int b, int c, int t, int mi, int ui);
        int eff, acc, low, fn, grp, x, y, o, r, cnt, s;
        m_pol = (ui + UB) % 5;
        eff = (mi + MB) % 64;
        acc = (m_pol == 0 || m_pol == 4) ||
              (m_pol == 1 && a != m_pa) || (m_pol == 2 && b != m_pb) ||
              (m_pol == 3 && (a != m_pa || b != m_pb));
        m_act = acc ? eff : m_held;
        m_held = m_act; m_pa = a; m_pb = b;
        low = m_act % 32; fn = low % 8;
        grp = (m_act >= 32) ? 0 : low / 8;
        x = (grp == 2) ? b : a;
        y = (grp == 0) ? b : c;
        cnt = a + b + c;
        if (grp == 3) begin
            case (fn)
                0: o = (cnt == 3);
                1: o = (cnt != 3);
                2: o = (cnt != 0);
                3: o = (cnt == 0);
                4: o = (cnt == 1 || cnt == 3);
                5: o = (cnt == 0 || cnt == 2);
                6: o = (cnt == 1);
                default: o = (cnt == 2);
            endcase
        end else begin
            case (fn)
                0: o = x & y;
                1: o = 1 - (x & y);
                2: o = x | y;
                3: o = 1 - (x | y);
                4: o = x ^ y;
                5: o = 1 - (x ^ y);
                6: begin
                    if (y == 1 && m_arm == 0) begin m_hb = x; m_arm = 1; end
                    else if (m_arm == 1 && y == 0) m_arm = 0;
                    o = m_hb;
                end
                default: begin
                    if (y == 1) m_hb = x;
                    o = m_hb;
                end
            endcase
        end
        if (m_act >= 32) begin
            case (low / 8)
                0: r = c & o;
                1: r = c ? 0 : o;
                2: r = c ? 1 - o : o;
                default: r = c ? o : m_post;
            endcase
        end else r = o;
        m_post = r;
        if (m_pol == 4) begin
            s = m_cap;
            if (t == 1 && m_tarm == 0) begin m_tarm = 1; m_cap = r; end
            else if (m_tarm == 1 && t == 0) m_tarm = 0;
        end else s = r;
        m_out = s;
    endtask

    task automatic check(string tag, int exp_v);
        total++;
        if (int'(out) != exp_v) begin
            bad++;
            $display("FAIL %s out=%0d expected=%0d", tag, out, exp_v);
        end
    endtask

    // called at a negedge: drive, model, pass an edge, compare at next negedge
    task automatic step(bit e, bit a, bit b, bit c, bit t, int mi, int ui, string tag);
        string tg;
        en = e; in_a = a; in_b = b; in_c = c; trig = t;
        mode_in = 6'(mi); upd_in = 3'(ui);
        tg = tag;
        if (e) begin
            model_step(a, b, c, t, mi, ui);
            if (tg == "") tg = auto_tag(m_pol, m_act);
        end else if (tg == "") tg = "R2";
        @(posedge clk);
        @(negedge clk);
        check(tg, m_out);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1", 0);

        // R8: 60 + 5 wraps to mode 1 (NAND); policy (3+2)%5 = 0
        step(1, 1, 1, 0, 0, 60, 3, "R8");
        step(1, 1, 0, 0, 0, 60, 3, "R8");
        // R8: 58 + 5 = 63 -> post keep, XNOR-free track: func 7 on (a,b)
        step(1, 1, 1, 1, 0, 58, 3, "R8");
        step(1, 0, 1, 0, 0, 58, 3, "R8");

        // R2: disabled steps with toggling inputs and mode
        step(0, 0, 0, 1, 1, 10, 1, "R2");
        step(0, 1, 1, 0, 0, 20, 4, "R2");

        // R9: set AND (59+5=64 -> 0) then policy 1 (4+2=6 -> 1)
        step(1, 0, 0, 0, 0, 59, 3, "R9");
        step(1, 0, 1, 0, 0, 61, 4, "R9");   // a unchanged: AND kept, expect 0
        step(1, 1, 0, 0, 0, 61, 4, "R9");   // a changed: OR taken, expect 1
        step(1, 1, 0, 0, 0, 59, 5, "R9");   // policy 2, b unchanged: OR kept
        step(1, 1, 1, 0, 0, 59, 6, "R9");   // policy 3, b changed: AND

        // R4: sample-and-hold mode 6 (1+5), arm prevents re-load
        step(1, 1, 1, 0, 0, 1, 3, "R4");
        step(1, 0, 1, 0, 0, 1, 3, "R4");
        step(1, 0, 0, 0, 0, 1, 3, "R4");
        step(1, 0, 1, 0, 0, 1, 3, "R4");

        // R5: track-and-hold mode 15 (10+5) on (a,c)
        step(1, 1, 0, 1, 0, 10, 3, "R5");
        step(1, 0, 0, 0, 0, 10, 3, "R5");

        // R6: exactly two high, mode 31 (26+5)
        step(1, 1, 1, 0, 0, 26, 3, "R6");
        step(1, 1, 1, 1, 0, 26, 3, "R6");

        // R7: invert post-stage, mode 48 (43+5) with AND
        step(1, 1, 1, 1, 0, 43, 3, "R7");
        step(1, 1, 1, 0, 0, 43, 3, "R7");

        // R10: policy 4 (2+2), OR mode 2 (61+5=66 -> 2)
        step(1, 1, 0, 0, 0, 61, 2, "R10");
        step(1, 1, 0, 0, 1, 61, 2, "R10");
        step(1, 0, 0, 0, 1, 61, 2, "R10");
        step(1, 0, 0, 0, 0, 61, 2, "R10");
        step(1, 0, 0, 0, 1, 61, 2, "R10");
        step(1, 0, 0, 0, 0, 61, 2, "R10");

        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 8) != 0, $urandom % 2, $urandom % 2, $urandom % 2,
                 $urandom % 2, $urandom % 64, $urandom % 8, "");
        end

        // R1: mid-run reset
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        check("R1", 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule